// File: doc/BRIEF.md
# Buffered Video Memory Data Port

This block gives a processor byte-wide access into a 14-bit video memory space through four registers:

- **Control.** Bit 2 chooses the pointer step.
- **Status.** Reading it resets the address byte sequence.
- **Address.** Two byte writes set the pointer.
- **Data.** Reads and writes go through the pointer, and the pointer moves after every access.

Most of the space sits in an external synchronous memory. That memory cannot answer within one processor access, so a read of that space returns the byte fetched by the previous read. The new byte is then fetched into a one-byte holding register.

The top 256 addresses (0x3F00 to 0x3FFF) are served by a small on-chip palette RAM. A read there answers at once. It still refreshes the holding register from the external byte that lies beneath, at the address minus 0x1000. A later ordinary read can therefore recover that hidden external byte.

The processor presents one access as a single-cycle strobe. Read data appears on the following cycle. Successive strobes must be at least four cycles apart, so that the external fetch has landed before the next access.

Top module: `vmem_port`

## Requirements
- R1: On register select 2 (address), the first write after reset or after a status read (select 1) supplies pointer bits 13:8 from data bits 5:0. The next write supplies bits 7:0 and completes the pointer.
- R2: Every access through register select 3 (data) advances the pointer. The step is 1 when control bit 2 is 0 and 32 when it is 1. The last control write (select 0) sets that bit. The pointer wraps modulo 2^14.
- R3: A data read at a pointer below 0x3F00 returns the holding register's content. The holding register is then reloaded with the external byte at that pointer.
- R4: After reset the holding register holds 0x00, so the first data read of a non-palette address returns 0x00.
- R5: A data read at a pointer from 0x3F00 to 0x3FFF returns palette entry pointer[4:0] on the next cycle, with no one-read delay.
- R6: A palette-range data read also reloads the holding register, from the external byte at pointer minus 0x1000.
- R7: A data write below 0x3F00 produces one external write cycle with the written byte, one cycle after the strobe. A data write at or above 0x3F00 updates palette entry pointer[4:0] and produces no external write.
- R8: A data read advances the pointer exactly as a write does, so a read can be used to skip a location before a write.
- R9: External addresses from 0x3000 to 0x3FFF are presented as the address minus 0x1000. The external address never has bits 13:12 both set.
- R10: Every data read raises the external read enable for exactly one cycle, the cycle after the strobe, with the mapped address of the pointer as it stood at the strobe.
- R11: Data writes, and all accesses to selects 0, 1 and 2, leave the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | One-cycle access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 2 | Register select: 0 control, 1 status, 2 address, 3 data |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after the strobe |
| ext_addr | output | 14 | External memory address |
| ext_re | output | 1 | External read enable |
| ext_we | output | 1 | External write enable |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, valid the cycle after ext_re |

## Verification
The read data is registered once, so it is due on the cycle after the strobe. The external enables and address are also due in that cycle. The bench drives each strobe on a falling edge and samples all of these at the next falling edge, one rising edge later.

The reloaded holding byte only shows up in the result of the next data read. The bench therefore leaves three idle cycles after every access. It then compares each read against its own model: the palette contents, the pointer, and the previously fetched external byte, which it computes arithmetically from the address.

// File: rtl/vmem_pkg.sv
// vmem_pkg: shared register select codes and address mapping for the video
// memory data port. Assumes a 14-bit space whose top quarter mirrors the
// quarter below it toward external memory.
package vmem_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_DATA = 2'd3
    } vsel_e;

    // Fold 0x3000-0x3FFF down onto 0x2000-0x2FFF for the external device.
    function automatic logic [13:0] ext_map(input logic [13:0] a);
        return (a[13:12] == 2'b11) ? {2'b10, a[11:0]} : a;
    endfunction

endpackage

// File: rtl/vmem_addr_ctrl.sv
// vmem_addr_ctrl: holds the access pointer, the byte-sequence toggle and the
// step-select bit. Assumes at most one strobe-derived command per cycle.
module vmem_addr_ctrl #(
    parameter int AW        = 14,
    parameter int DW        = 8,
    parameter int STEP_WIDE = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          rd_stat,
    input  logic          wr_addr,
    input  logic          data_acc,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] ptr
);
    localparam int HI_W = AW - DW;

    logic            step_wide;
    logic            second;
    logic [HI_W-1:0] hi_hold;
    logic [AW-1:0]   step;

    assign step = step_wide ? AW'(STEP_WIDE) : AW'(1);

    // Step select is bit 2 of each control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       step_wide <= 1'b0;
        else if (wr_ctrl) step_wide <= wdata[2];
    end

    // Address byte sequencing: high byte first, low byte completes the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second  <= 1'b0;
            hi_hold <= '0;
        end else if (rd_stat) begin
            second  <= 1'b0;
        end else if (wr_addr) begin
            second  <= ~second;
            if (!second) hi_hold <= wdata[HI_W-1:0];
        end
    end

    // Pointer load on the second address byte, advance on every data access.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ptr <= '0;
        else if (wr_addr && second && !rd_stat) ptr <= {hi_hold, wdata};
        else if (data_acc)           ptr <= ptr + step;
    end
endmodule

// File: rtl/vmem_read_buf.sv
// vmem_read_buf: one-byte holding register with its external fetch sequence.
// A fetch request raises the read enable for one cycle. The external device
// answers one cycle later and the byte is captured on the edge after that.
// Assumes no new request arrives before the capture.
module vmem_read_buf #(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_go,
    input  logic [DW-1:0] ext_rdata,
    output logic          ext_re,
    output logic [DW-1:0] rbuf
);
    logic fill_q;

    // Fetch pipeline: request cycle, then capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_re <= 1'b0;
            fill_q <= 1'b0;
        end else begin
            ext_re <= fetch_go;
            fill_q <= ext_re;
        end
    end

    // Holding register loads only from a completed fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)      rbuf <= RESET_VAL;
        else if (fill_q) rbuf <= ext_rdata;
    end
endmodule

// File: rtl/vmem_palette.sv
// vmem_palette: small on-chip RAM with synchronous write and combinational
// read, so that palette reads need no extra cycle. Contents are not reset.
module vmem_palette #(
    parameter int PW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << PW;

    logic [DW-1:0] mem [DEPTH];

    // Entry write.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/vmem_port.sv
// vmem_port: processor data port into a 14-bit video memory space. The
// processor strobes one register access per cycle, with strobes at least four
// cycles apart. Reads of external space are delayed by one read through a
// holding byte. Palette reads answer at once but still refill the holding byte.
module vmem_port #(
    parameter int            AW        = 14,
    parameter int            DW        = 8,
    parameter int            PW        = 5,
    parameter int            STEP_WIDE = 32,
    parameter logic [DW-1:0] RESET_BUF = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_sel,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_reg,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic [AW-1:0] ext_addr,
    output logic          ext_re,
    output logic          ext_we,
    output logic [DW-1:0] ext_wdata,
    input  logic [DW-1:0] ext_rdata
);
    import vmem_pkg::*;

    localparam int HI_W = AW - DW;

    vsel_e         sel;
    logic          wr_ctrl, rd_stat, wr_addr, data_rd, data_wr;
    logic [AW-1:0] ptr;
    logic          in_pal;
    logic [DW-1:0] pal_rdata;
    logic [DW-1:0] rbuf_q;

    assign sel     = vsel_e'(cpu_reg);
    assign wr_ctrl = cpu_sel &  cpu_we & (sel == SEL_CTRL);
    assign rd_stat = cpu_sel & ~cpu_we & (sel == SEL_STAT);
    assign wr_addr = cpu_sel &  cpu_we & (sel == SEL_ADDR);
    assign data_rd = cpu_sel & ~cpu_we & (sel == SEL_DATA);
    assign data_wr = cpu_sel &  cpu_we & (sel == SEL_DATA);
    assign in_pal  = (ptr[AW-1:DW] == {HI_W{1'b1}});

    vmem_addr_ctrl #(.AW(AW), .DW(DW), .STEP_WIDE(STEP_WIDE)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .rd_stat  (rd_stat),
        .wr_addr  (wr_addr),
        .data_acc (data_rd | data_wr),
        .wdata    (cpu_wdata),
        .ptr      (ptr)
    );

    vmem_read_buf #(.DW(DW), .RESET_VAL(RESET_BUF)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_go  (data_rd),
        .ext_rdata (ext_rdata),
        .ext_re    (ext_re),
        .rbuf      (rbuf_q)
    );

    vmem_palette #(.PW(PW), .DW(DW)) u_pal (
        .clk   (clk),
        .we    (data_wr & in_pal),
        .addr  (ptr[PW-1:0]),
        .wdata (cpu_wdata),
        .rdata (pal_rdata)
    );

    // External address and write cycle, issued the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_addr  <= '0;
            ext_we    <= 1'b0;
            ext_wdata <= '0;
        end else begin
            ext_we <= data_wr & ~in_pal;
            if (data_rd | data_wr) ext_addr <= ext_map(ptr);
            if (data_wr)           ext_wdata <= cpu_wdata;
        end
    end

    // Read data: palette direct, otherwise the held byte; other reads give 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cpu_rdata <= '0;
        else if (data_rd)            cpu_rdata <= in_pal ? pal_rdata : rbuf_q;
        else if (cpu_sel && !cpu_we) cpu_rdata <= '0;
    end
endmodule

// File: rtl/vmem_port_chk.sv
// vmem_port_chk: temporal checks on the data port, bound to every vmem_port.
module vmem_port_chk #(
    parameter int            AW        = 14,
    parameter int            DW        = 8,
    parameter logic [DW-1:0] RESET_BUF = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_sel,
    input logic          cpu_we,
    input logic [1:0]    cpu_reg,
    input logic [AW-1:0] ext_addr,
    input logic          ext_re,
    input logic          ext_we,
    input logic [DW-1:0] rbuf_q
);
    // R10
    fetch_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_we && cpu_reg == 2'd3) |=> ext_re);

    // R10
    fetch_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_re |=> !ext_re);

    // R7
    no_read_write_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_re && ext_we));

    // R9
    ext_addr_folded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_re || ext_we) |-> (ext_addr[AW-1:AW-2] != 2'b11));

    // R11
    buf_only_from_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ext_re, 2) |-> $stable(rbuf_q));

    // R4
    buf_reset_value_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (rbuf_q == RESET_BUF));
endmodule

bind vmem_port vmem_port_chk #(.AW(AW), .DW(DW), .RESET_BUF(RESET_BUF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_sel  (cpu_sel),
    .cpu_we   (cpu_we),
    .cpu_reg  (cpu_reg),
    .ext_addr (ext_addr),
    .ext_re   (ext_re),
    .ext_we   (ext_we),
    .rbuf_q   (rbuf_q)
);

// File: tb/vmem_port_test.sv
// vmem_port_test: drives register accesses and compares against a bench model
// of the pointer, the palette and the holding byte. External memory content is
// computed from the address.
module vmem_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_reg = '0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata;
    logic [13:0] ext_addr;
    logic        ext_re, ext_we;
    logic [7:0]  ext_wdata, ext_rdata;

    int nvec = 0, nbad = 0;

    // Bench model state.
    logic [13:0] mp = '0;
    logic        mwide = 1'b0;
    logic [7:0]  mbuf = 8'h00;
    logic [7:0]  mpal [32];
    logic [7:0]  s_rd, s_ewd;
    logic [13:0] s_ea;
    logic        s_re, s_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmem_port uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ext_addr(ext_addr), .ext_re(ext_re), .ext_we(ext_we),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    function automatic logic [7:0] extf(input logic [13:0] a);
        return a[7:0] ^ {2'b10, a[13:8]};
    endfunction

    function automatic logic [13:0] fold(input logic [13:0] a);
        return (a[13:12] == 2'b11) ? (a - 14'h1000) : a;
    endfunction

    // Synchronous external memory model: computed content.
    always_ff @(posedge clk) begin
        if (ext_re) ext_rdata <= extf(ext_addr);
    end

    task automatic chk(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] r, input logic w, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = w; cpu_reg = r; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
        s_rd = cpu_rdata; s_re = ext_re; s_we = ext_we; s_ea = ext_addr; s_ewd = ext_wdata;
        repeat (3) @(negedge clk);
    endtask

    task automatic setp(input logic [7:0] hi, input logic [7:0] lo);
        acc(2'd2, 1'b1, hi);
        acc(2'd2, 1'b1, lo);
        mp = {hi[5:0], lo};
    endtask

    task automatic setctl(input logic wide);
        acc(2'd0, 1'b1, {5'b0, wide, 2'b0});
        mwide = wide;
    endtask

    task automatic adv();
        mp = mp + (mwide ? 14'd32 : 14'd1);
    endtask

    task automatic dread(input string req);
        logic [7:0] e;
        logic pal;
        pal = (mp[13:8] == 6'h3F);
        e = pal ? mpal[mp[4:0]] : mbuf;
        acc(2'd3, 1'b0, 8'h00);
        chk(s_rd == e, req, {8'h0, s_rd}, {8'h0, e});
        chk(s_re && s_ea == fold(mp), {req, " R10 fetch"}, {1'b0, s_re, s_ea}, {2'b01, fold(mp)});
        mbuf = extf(fold(mp));
        adv();
    endtask

    task automatic dwrite(input logic [7:0] v, input string req);
        acc(2'd3, 1'b1, v);
        if (mp[13:8] == 6'h3F) begin
            mpal[mp[4:0]] = v;
            chk(!s_we, {req, " no ext write"}, {15'h0, s_we}, 16'h0);
        end else begin
            chk(s_we && s_ea == mp && s_ewd == v, req, {s_we, s_ea[6:0], s_ewd},
                {1'b1, mp[6:0], v});
        end
        adv();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nbad++;
        nvec++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state of outputs.
        chk(cpu_rdata == 8'h00 && !ext_re && !ext_we, "R4 reset outputs",
            {cpu_rdata, 6'h0, ext_re, ext_we}, 16'h0);

        // R3 R4: first read gives the reset byte, then one-read-late data.
        setctl(1'b0);
        setp(8'h01, 8'h00);
        for (int i = 0; i < 6; i++) dread("R3 delayed read step 1");

        // R2: wide step.
        setctl(1'b1);
        setp(8'h20, 8'h40);
        for (int i = 0; i < 5; i++) dread("R2 step 32 read");

        // R7: fill the palette.
        setctl(1'b0);
        setp(8'h3F, 8'h00);
        for (int i = 0; i < 32; i++) dwrite(8'(i * 9 + 5), "R7 palette write");

        // R5 R6: palette read is immediate, then the hidden byte is recovered.
        for (int i = 0; i < 32; i++) begin
            setp(8'h3F, 8'(i));
            dread("R5 palette direct read");
            setp(8'h10, 8'h00);
            dread("R6 hidden byte below palette");
        end

        // R9: mirrored region is folded toward external memory.
        setp(8'h31, 8'h23);
        dread("R9 mirror read");
        dread("R9 mirror data returned");

        // R2: wrap at the top of the 14-bit space, both steps.
        setp(8'h3F, 8'hFF);
        dread("R2 wrap step 1 source");
        dread("R2 wrap step 1 to zero");
        setctl(1'b1);
        setp(8'h3F, 8'hE5);
        dread("R2 wrap step 32 source");
        dread("R2 wrap step 32 to 0x0005");

        // R7 R11: writes and other registers leave the held byte alone.
        setctl(1'b0);
        setp(8'h05, 8'h00);
        dread("R11 prime held byte");
        dwrite(8'hA7, "R7 external write");
        acc(2'd1, 1'b0, 8'h00);
        chk(s_rd == 8'h00, "R11 status read value", {8'h0, s_rd}, 16'h0);
        setctl(1'b0);
        setp(8'h06, 8'h00);
        dread("R11 held byte unchanged");

        // R1: status read restarts the address byte sequence.
        acc(2'd2, 1'b1, 8'h12);
        acc(2'd1, 1'b0, 8'h00);
        setp(8'h07, 8'h40);
        dread("R1 pointer after toggle reset");

        // R8: a read skips a location before a write.
        setp(8'h08, 8'h00);
        dread("R8 skip read");
        dwrite(8'h3C, "R8 write lands after skip");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule